// File: doc/BRIEF.md
# External Sync Arm Controller

This block lines up data capture across the channels of one converter instance, and across several instances, on a shared external sync input. Software writes three self-clearing command bits through a register write port. The bits arm the trigger, disarm it, or ask for a manual sync event. Once armed, the block waits for a low-to-high transition on the sync input. It then sends one single-cycle pulse to every channel datapath at the same time and drops its armed state.

The sync input may be asynchronous. It passes through a synchronizer chain and then an edge detector. Because of the edge detector, an input that is already high when the block is armed does not fire. A manual request drives a one-cycle pulse on a separate internal sync output and does not touch the armed state. A status output reads 1 while the block waits for the trigger and after a sync has completed. A disarm clears it. A build-time switch removes the whole command path. With the switch off, the command bits read 0 and have no effect.

Top module: `esync_arm_ctrl`

## Requirements
- R1: While `rstN` is low and right after it rises, `cmdRead`, `chanSync`, `intSyncOut` and `syncStatus` are all 0.
- R2: A write (`cmdWrEn` high for one cycle) stores `cmdWrData` into the command register. Bit 0 is arm, bit 1 is disarm and bit 2 is manual request. The stored bits read back on `cmdRead` for exactly one cycle and then return to 0 on their own.
- R3: The block is armed from the cycle after the arm bit shows on `cmdRead`. The sync input passes through two flops, so `chanSync` rises at the third rising clock edge after `syncIn` goes high, provided the block is armed in the cycle before that edge. An input that rises earlier, and is still high at arming, never fires.
- R4: A sync event drives all `NUM_CHAN` bits of `chanSync` high together for exactly one cycle. At all other times every bit is 0.
- R5: The armed state clears at the edge that emits the pulse. A later rising edge on `syncIn` without a new arm gives no pulse.
- R6: The disarm bit cancels a pending arm and suppresses any pulse in that cycle. If arm and disarm are written together, disarm wins, no pulse follows, and `syncStatus` reads 0.
- R7: A manual request raises `intSyncOut` for one cycle, at the edge after the request shows on `cmdRead`. It leaves `chanSync` at 0 and leaves the armed state as it was.
- R8: `syncStatus` is 1 while the block is armed and after a pulse has been emitted. It returns to 0 only through disarm or reset.
- R9: With `SYNC_ENABLE` = 0, `cmdRead`, `chanSync`, `intSyncOut` and `syncStatus` stay 0 whatever is written or applied on `syncIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | One-cycle write strobe for the command register |
| cmdWrData | input | 3 | Command bits: [0] arm, [1] disarm, [2] manual request |
| cmdRead | output | 3 | Readback of the self-clearing command register |
| syncIn | input | 1 | External sync input, may be asynchronous |
| chanSync | output | NUM_CHAN | Sync pulse fanned out to every channel datapath |
| intSyncOut | output | 1 | Internal sync pulse from a manual request |
| syncStatus | output | 1 | 1 while armed and after a completed sync |

## Verification
A stuck armed flag shows up within a few cycles. Either a second edge on `syncIn` produces an extra `chanSync` pulse, or a disarmed block still reports `syncStatus` high on the cycle after the disarm. An edge detector that misses its history register fires on a level that was already high when the block was armed. This is caught by sweeping the sync rise from four cycles before the arm write to three cycles after it, and comparing against the single cycle where the pulse is due. A fault in the self-clearing command register shows on `cmdRead` one cycle after the write.

// File: rtl/esync_pkg.sv
package esync_pkg;
  localparam int CMD_W          = 3;
  localparam int CMD_ARM_BIT    = 0;
  localparam int CMD_DISARM_BIT = 1;
  localparam int CMD_MANUAL_BIT = 2;

  // Strobes handed from the control to the datapath each cycle
  typedef struct packed {
    logic syncFire;
    logic manualReq;
  } syncStrobe_t;
endpackage

// File: rtl/esync_datapath.sv
module esync_datapath
  import esync_pkg::*;
#(
  parameter int NUM_CHAN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                syncIn,
  input  syncStrobe_t         strobes,
  output logic                syncRise,
  output logic [NUM_CHAN-1:0] chanSync,
  output logic                intSyncOut
);
  // synchronizer stages plus one history flop for edge detection
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] syncPipe;

  always_ff @(posedge clk) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[PIPE_W-2:0], syncIn};
  end

  assign syncRise = syncPipe[SYNC_STAGES-1] & ~syncPipe[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanSync   <= '0;
      intSyncOut <= 1'b0;
    end else begin
      chanSync   <= {NUM_CHAN{strobes.syncFire}};
      intSyncOut <= strobes.manualReq;
    end
  end
endmodule

// File: rtl/esync_ctrl.sv
module esync_ctrl
  import esync_pkg::*;
#(
  parameter bit SYNC_ENABLE = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWrEn,
  input  logic [CMD_W-1:0] cmdWrData,
  input  logic             syncRise,
  output logic [CMD_W-1:0] cmdRead,
  output syncStrobe_t      strobes,
  output logic             syncStatus
);
  logic [CMD_W-1:0] cmdReg;
  logic armed, syncDone;
  logic armReq, disarmReq, fire;

  generate
    if (SYNC_ENABLE) begin : g_cmd
      // a write holds for one cycle; absent a new write the bits self-clear
      always_ff @(posedge clk) begin
        if (!rstN)        cmdReg <= '0;
        else if (cmdWrEn) cmdReg <= cmdWrData;
        else              cmdReg <= '0;
      end
    end else begin : g_nocmd
      logic unusedWr;
      assign unusedWr = ^{cmdWrEn, cmdWrData};
      assign cmdReg   = '0;
    end
  endgenerate

  assign disarmReq = cmdReg[CMD_DISARM_BIT];
  assign armReq    = cmdReg[CMD_ARM_BIT] & ~disarmReq;
  assign fire      = armed & syncRise & ~disarmReq;

  // priority: disarm, then arm, then the clear caused by a fired pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed    <= 1'b0;
      syncDone <= 1'b0;
    end else begin
      if (disarmReq)   armed <= 1'b0;
      else if (armReq) armed <= 1'b1;
      else if (fire)   armed <= 1'b0;

      if (disarmReq)   syncDone <= 1'b0;
      else if (fire)   syncDone <= 1'b1;
    end
  end

  assign cmdRead           = cmdReg;
  assign strobes.syncFire  = fire;
  assign strobes.manualReq = cmdReg[CMD_MANUAL_BIT];
  assign syncStatus        = armed | syncDone;
endmodule

// File: rtl/esync_arm_ctrl.sv
module esync_arm_ctrl
  import esync_pkg::*;
#(
  parameter bit SYNC_ENABLE = 1'b1,
  parameter int NUM_CHAN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdWrEn,
  input  logic [CMD_W-1:0]    cmdWrData,
  output logic [CMD_W-1:0]    cmdRead,
  input  logic                syncIn,
  output logic [NUM_CHAN-1:0] chanSync,
  output logic                intSyncOut,
  output logic                syncStatus
);
  syncStrobe_t strobes;
  logic        syncRise;

  esync_ctrl #(.SYNC_ENABLE(SYNC_ENABLE)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdWrEn    (cmdWrEn),
    .cmdWrData  (cmdWrData),
    .syncRise   (syncRise),
    .cmdRead    (cmdRead),
    .strobes    (strobes),
    .syncStatus (syncStatus)
  );

  esync_datapath #(.NUM_CHAN(NUM_CHAN), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .syncIn     (syncIn),
    .strobes    (strobes),
    .syncRise   (syncRise),
    .chanSync   (chanSync),
    .intSyncOut (intSyncOut)
  );
endmodule

// File: rtl/esync_arm_ctrl_checker.sv
module esync_arm_ctrl_checker #(
  parameter bit SYNC_ENABLE = 1'b1,
  parameter int NUM_CHAN    = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic [2:0]          cmdRead,
  input logic [NUM_CHAN-1:0] chanSync,
  input logic                intSyncOut,
  input logic                syncStatus
);
  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    chanSync[0] |=> !chanSync[0]);

  p_chan_aligned_r4: assert property (@(posedge clk) disable iff (!rstN)
    (chanSync == '0) || (chanSync == '1));

  p_pulse_sets_status_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chanSync[0]) |-> syncStatus);

  p_disarm_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmdRead[1] |=> (!syncStatus && chanSync == '0));

  p_manual_follows_cmd_r7: assert property (@(posedge clk) disable iff (!rstN)
    intSyncOut |-> $past(cmdRead[2]));

  generate
    if (!SYNC_ENABLE) begin : g_off
      p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rstN)
        cmdRead == '0 && chanSync == '0 && !syncStatus && !intSyncOut);
    end
  endgenerate
endmodule

bind esync_arm_ctrl esync_arm_ctrl_checker #(
  .SYNC_ENABLE(SYNC_ENABLE),
  .NUM_CHAN   (NUM_CHAN)
) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .cmdRead    (cmdRead),
  .chanSync   (chanSync),
  .intSyncOut (intSyncOut),
  .syncStatus (syncStatus)
);

// File: tb/esync_arm_ctrl_bench.sv
module esync_arm_ctrl_bench;
  localparam int NCH = 4;
  localparam logic [2:0] ARM = 3'b001, DISARM = 3'b010, MANUAL = 3'b100;
  localparam logic [NCH-1:0] ALLCH = {NCH{1'b1}};

  logic clk = 1'b0, rstN = 1'b0, cmdWrEn = 1'b0, syncIn = 1'b0;
  logic [2:0] cmdWrData = '0;
  logic [2:0] cmdRead, offRead;
  logic [NCH-1:0] chanSync, offChan;
  logic intSyncOut, syncStatus, offInt, offStatus;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  esync_arm_ctrl #(.SYNC_ENABLE(1'b1), .NUM_CHAN(NCH)) u_esync_arm_ctrl (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .cmdRead(cmdRead), .syncIn(syncIn), .chanSync(chanSync),
    .intSyncOut(intSyncOut), .syncStatus(syncStatus));

  esync_arm_ctrl #(.SYNC_ENABLE(1'b0), .NUM_CHAN(NCH)) u_esync_off (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .cmdRead(offRead), .syncIn(syncIn), .chanSync(offChan),
    .intSyncOut(offInt), .syncStatus(offStatus));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // advance one cycle; the disabled instance must stay silent (R9)
  task automatic step();
    @(negedge clk);
    if (rstN)
      check("R9 disabled instance quiet",
            32'({offRead, offChan, offInt, offStatus}), 32'd0);
  endtask

  task automatic write(logic [2:0] cmd);
    cmdWrEn = 1'b1; cmdWrData = cmd;
    step();
    cmdWrEn = 1'b0; cmdWrData = '0;
  endtask

  task automatic clean();
    write(DISARM);
    syncIn = 1'b0;
    repeat (6) step();
  endtask

  task automatic expectNoPulse(string tag, int n);
    for (int k = 0; k < n; k++) begin
      step();
      check(tag, 32'(chanSync), 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 reset outputs", 32'({cmdRead, chanSync, intSyncOut, syncStatus}), 32'd0);
    rstN = 1'b1;
    step();
    check("R1 after reset", 32'({cmdRead, chanSync, intSyncOut, syncStatus}), 32'd0);

    // R2 readback and self-clear
    write(ARM);
    check("R2 cmd readback", 32'(cmdRead), 32'(ARM));
    step();
    check("R2 cmd self-cleared", 32'(cmdRead), 32'd0);
    check("R8 status while armed", 32'(syncStatus), 32'd1);
    clean();
    check("R8 status after disarm", 32'(syncStatus), 32'd0);

    // R3/R4 sweep of sync rise offset relative to the arm write
    for (int o = -4; o <= 3; o++) begin
      clean();
      for (int i = -4; i <= 10; i++) begin
        cmdWrEn   = (i == 0);
        cmdWrData = (i == 0) ? ARM : 3'b000;
        if (i == o) syncIn = 1'b1;
        step();
        check($sformatf("R3 R4 pulse offset %0d cycle %0d", o, i), 32'(chanSync),
              (o >= 0 && i == o + 2) ? 32'(ALLCH) : 32'd0);
      end
      cmdWrEn = 1'b0; cmdWrData = '0;
      check("R8 status after sweep", 32'(syncStatus), 32'd1);
    end

    // R5 second edge without re-arming
    syncIn = 1'b0;
    repeat (4) step();
    syncIn = 1'b1;
    expectNoPulse("R5 no pulse on second edge", 8);
    check("R8 status held after sync", 32'(syncStatus), 32'd1);

    // R6 disarm cancels a pending arm
    clean();
    write(ARM);
    step();
    write(DISARM);
    step();
    check("R6 status after disarm", 32'(syncStatus), 32'd0);
    syncIn = 1'b1;
    expectNoPulse("R6 disarmed no pulse", 8);

    // R6 arm and disarm together
    clean();
    write(ARM | DISARM);
    step();
    check("R6 arm+disarm status", 32'(syncStatus), 32'd0);
    syncIn = 1'b1;
    expectNoPulse("R6 arm+disarm no pulse", 8);

    // R7 manual request
    clean();
    write(MANUAL);
    check("R7 manual readback", 32'(cmdRead), 32'(MANUAL));
    check("R7 manual not yet", 32'(intSyncOut), 32'd0);
    step();
    check("R7 manual pulse", 32'(intSyncOut), 32'd1);
    check("R7 channels untouched", 32'(chanSync), 32'd0);
    step();
    check("R7 manual pulse ends", 32'(intSyncOut), 32'd0);

    // R7 manual leaves armed state alone
    write(ARM);
    step();
    write(MANUAL);
    repeat (2) step();
    check("R7 still armed after manual", 32'(syncStatus), 32'd1);
    syncIn = 1'b1;
    repeat (2) step();
    step();
    check("R7 armed fires after manual", 32'(chanSync), 32'(ALLCH));

    finishRun();
  end
endmodule